// File: doc/BRIEF.md
# Row Activation Throttler with Ageing Counting Filters

This block watches the stream of row activations going to a memory bank and estimates how often each row has been opened, without keeping a counter per row. Two counting Bloom filters share the work. Every activation is counted in both filters. At each epoch boundary, the filter that has been counting longer is wiped, and the other filter takes over as the active one. History older than about two epochs therefore drops out of the estimate. A row whose estimate in the active filter rises above a threshold goes into a small blacklist.

A scheduler asks the block about an activation it is about to issue. One cycle later it gets back two answers: whether the row is blacklisted, and whether the activation may go now. A blacklisted row is not refreshed as a countermeasure. Instead, its activations are spaced out: the next one is allowed only after a minimum number of cycles has passed since the last one. When the refresh logic reports that a row has been refreshed, the block halves that row's counters. A refreshed row then tends to leave the blacklist.

Top module: `athr_throttle`

## Requirements
- R1: After reset, `bl_count` is 0, `qry_bl_hit` is 0 and `qry_allow` is 1.
- R2: Each filter has four banks of `2**IDX_W` saturating counters. Hash k (k = 0..3) indexes bank k with the XOR of the zero-padded `IDX_W`-bit slices of `row ^ (row >> (k+1))`. An activation increments the four indexed counters in both filters. The row's estimate is the minimum of its four counters in the active filter after the update. When the estimate exceeds `THRESH`, the row is on the blacklist from the next cycle.
- R3: A query is answered one cycle after `qry_vld`. A row that is not blacklisted gives `qry_bl_hit`=0 and `qry_allow`=1. When no query is made, the outputs show 0 and 1.
- R4: For a blacklisted row, a query sampled at a clock edge is allowed only if at least `MIN_GAP` edges have passed since the edge that sampled that row's last activation. Each activation of the row restarts the spacing.
- R5: A refresh notice halves (shifts right by one) the row's four indexed counters in both filters. If the row's estimate is then at or below `THRESH`, the row leaves the blacklist.
- R6: Counters stop at `2**CNT_W-1` and do not wrap.
- R7: Suppose an activation and a refresh notice name the same row in the same cycle. The refresh wins and the activation is discarded. For different rows, each counter is halved if the refresh indexes it, and otherwise incremented if the activation indexes it.
- R8: The blacklist holds `BL_DEPTH` rows, and `bl_count` gives how many it holds. When it is full, a qualifying row is not added. A slot freed by a refresh can be reused.
- R9: Every `EPOCH_CYC` cycles after reset, the active filter is cleared, the other filter becomes active, and the blacklist is emptied. A row qualifies again on its next activation, judged by the newly active filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_vld | input | 1 | An activation was issued this cycle |
| act_row | input | ROW_W | Row of the issued activation |
| ref_vld | input | 1 | A row was refreshed this cycle |
| ref_row | input | ROW_W | Row that was refreshed |
| qry_vld | input | 1 | A proposed activation is queried |
| qry_row | input | ROW_W | Row of the proposed activation |
| qry_bl_hit | output | 1 | Queried row was blacklisted (registered) |
| qry_allow | output | 1 | Queried activation may proceed (registered) |
| bl_count | output | BLC_W | Number of rows on the blacklist |

## Verification
The properties assume that activation and refresh inputs arrive at most once each per cycle. They also assume that an activation reported to the block is one that actually happened. Under those assumptions, the blacklist can grow by at most one row per edge, and it cannot grow in a cycle with no effective activation. The bench drives every input on the falling edge as single-cycle pulses. It resets the block before each scenario, so each scenario starts with empty filters at the start of an epoch. It uses rows 1, 2 and 3, which share no counter in any bank under the stated hashes, so each row's estimate is exactly its own count.

// File: rtl/athr_pkg.sv
package athr_pkg;
   parameter int unsigned ATHR_NUM_HASH = 4;
endpackage

// File: rtl/athr_hash.sv
module athr_hash
   import athr_pkg::*;
#(
   parameter int ROW_W = 16,
   parameter int IDX_W = 6
) (
   input  logic [ROW_W-1:0]                    row,
   output logic [ATHR_NUM_HASH-1:0][IDX_W-1:0] idx
);
   localparam int NSL  = (ROW_W + IDX_W - 1) / IDX_W;
   localparam int PADW = NSL * IDX_W;

   for (genvar k = 0; k < ATHR_NUM_HASH; k++) begin : g_fold
      logic [PADW-1:0]  mix;
      logic [IDX_W-1:0] fold;
      always_comb begin
         mix  = PADW'(row ^ (row >> (k + 1)));
         fold = '0;
         for (int s = 0; s < NSL; s++) fold = fold ^ mix[s*IDX_W +: IDX_W];
      end
      assign idx[k] = fold;
   end
endmodule

// File: rtl/athr_cbf.sv
module athr_cbf
   import athr_pkg::*;
#(
   parameter int IDX_W = 6,
   parameter int CNT_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clr,
   input  logic                                inc_en,
   input  logic [ATHR_NUM_HASH-1:0][IDX_W-1:0] inc_idx,
   input  logic                                hd_en,
   input  logic [ATHR_NUM_HASH-1:0][IDX_W-1:0] hd_idx,
   output logic [CNT_W-1:0]                    inc_min,
   output logic [CNT_W-1:0]                    hd_min
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] cnt_q [ATHR_NUM_HASH][DEPTH];
   logic [CNT_W-1:0] cnt_d [ATHR_NUM_HASH][DEPTH];

   always_comb begin
      for (int k = 0; k < ATHR_NUM_HASH; k++) begin
         for (int j = 0; j < DEPTH; j++) begin
            logic [CNT_W-1:0] base;
            base = clr ? '0 : cnt_q[k][j];
            if (hd_en && hd_idx[k] == IDX_W'(j))
               cnt_d[k][j] = base >> 1;
            else if (inc_en && inc_idx[k] == IDX_W'(j))
               cnt_d[k][j] = (base == CMAX) ? base : base + 1'b1;
            else
               cnt_d[k][j] = base;
         end
      end
   end

   always_comb begin
      inc_min = CMAX;
      hd_min  = CMAX;
      for (int k = 0; k < ATHR_NUM_HASH; k++) begin
         if (cnt_d[k][inc_idx[k]] < inc_min) inc_min = cnt_d[k][inc_idx[k]];
         if (cnt_d[k][hd_idx[k]]  < hd_min)  hd_min  = cnt_d[k][hd_idx[k]];
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < ATHR_NUM_HASH; k++)
         for (int j = 0; j < DEPTH; j++)
            cnt_q[k][j] <= rst_n ? cnt_d[k][j] : '0;
   end
endmodule

// File: rtl/athr_blist.sv
module athr_blist #(
   parameter int ROW_W    = 16,
   parameter int BL_DEPTH = 8,
   parameter int MIN_GAP  = 16,
   localparam int GAP_W   = $clog2(MIN_GAP + 1),
   localparam int BLC_W   = $clog2(BL_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             add_en,
   input  logic [ROW_W-1:0] add_row,
   input  logic             rm_en,
   input  logic [ROW_W-1:0] rm_row,
   input  logic             touch_en,
   input  logic [ROW_W-1:0] touch_row,
   input  logic [ROW_W-1:0] qry_row,
   output logic             qry_hit,
   output logic             qry_gap_ok,
   output logic [BLC_W-1:0] count
);
   typedef struct packed {
      logic             vld;
      logic [ROW_W-1:0] row;
      logic [GAP_W-1:0] gap;
   } ent_t;

   localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

   ent_t ent_q [BL_DEPTH];
   ent_t ent_d [BL_DEPTH];
   logic present, free_found, add_new;
   int   free_sel;

   always_comb begin
      present    = 1'b0;
      free_found = 1'b0;
      free_sel   = 0;
      for (int i = 0; i < BL_DEPTH; i++) begin
         if (ent_q[i].vld && ent_q[i].row == add_row) present = 1'b1;
         if (!free_found && (!ent_q[i].vld || flush)) begin
            free_found = 1'b1;
            free_sel   = i;
         end
      end
      add_new = add_en && (flush || !present) && free_found;

      for (int i = 0; i < BL_DEPTH; i++) begin
         ent_d[i] = ent_q[i];
         if (ent_q[i].gap != GAP_MAX) ent_d[i].gap = ent_q[i].gap + 1'b1;
         if (touch_en && ent_q[i].vld && ent_q[i].row == touch_row) ent_d[i].gap = '0;
         if (rm_en && ent_q[i].vld && ent_q[i].row == rm_row) ent_d[i].vld = 1'b0;
         if (flush) ent_d[i].vld = 1'b0;
         if (add_new && free_sel == i) begin
            ent_d[i].vld = 1'b1;
            ent_d[i].row = add_row;
            ent_d[i].gap = '0;
         end
      end
   end

   always_comb begin
      qry_hit    = 1'b0;
      qry_gap_ok = 1'b1;
      count      = '0;
      for (int i = 0; i < BL_DEPTH; i++) begin
         if (ent_q[i].vld) count = count + 1'b1;
         if (ent_q[i].vld && ent_q[i].row == qry_row) begin
            qry_hit    = 1'b1;
            qry_gap_ok = (ent_q[i].gap >= GAP_MAX);
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < BL_DEPTH; i++)
         ent_q[i] <= rst_n ? ent_d[i] : '0;
   end
endmodule

// File: rtl/athr_throttle.sv
module athr_throttle
   import athr_pkg::*;
#(
   parameter int ROW_W     = 16,
   parameter int IDX_W     = 6,
   parameter int CNT_W     = 8,
   parameter int THRESH    = 200,
   parameter int EPOCH_CYC = 65536,
   parameter int MIN_GAP   = 16,
   parameter int BL_DEPTH  = 8,
   localparam int BLC_W    = $clog2(BL_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_vld,
   input  logic [ROW_W-1:0] act_row,
   input  logic             ref_vld,
   input  logic [ROW_W-1:0] ref_row,
   input  logic             qry_vld,
   input  logic [ROW_W-1:0] qry_row,
   output logic             qry_bl_hit,
   output logic             qry_allow,
   output logic [BLC_W-1:0] bl_count
);
   localparam int EP_W = $clog2(EPOCH_CYC);

   if (THRESH < 1 || THRESH >= (1 << CNT_W) - 1) begin : g_bad_thresh
      $error("THRESH must lie inside the counter range");
   end
   if (EPOCH_CYC < 2) begin : g_bad_epoch
      $error("EPOCH_CYC must be at least 2");
   end
   if (MIN_GAP < 1 || BL_DEPTH < 1) begin : g_bad_size
      $error("MIN_GAP and BL_DEPTH must be positive");
   end
   if (IDX_W < 1 || IDX_W > ROW_W) begin : g_bad_idx
      $error("IDX_W must be between 1 and ROW_W");
   end

   logic [EP_W-1:0] ep_cnt;
   logic            act_sel, nxt_sel, ep_wrap;
   logic            same_row, act_eff;
   logic [ATHR_NUM_HASH-1:0][IDX_W-1:0] act_idx, ref_idx;
   logic [1:0][CNT_W-1:0] inc_min, hd_min;
   logic [CNT_W-1:0]      est_act, est_ref;
   logic                  add_en, rm_en, hit_w, gap_ok_w;

   assign ep_wrap  = (ep_cnt == EP_W'(EPOCH_CYC - 1));
   assign nxt_sel  = ep_wrap ? ~act_sel : act_sel;
   assign same_row = act_vld && ref_vld && (act_row == ref_row);
   assign act_eff  = act_vld && !same_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ep_cnt  <= '0;
         act_sel <= 1'b0;
      end else begin
         ep_cnt  <= ep_wrap ? '0 : ep_cnt + 1'b1;
         act_sel <= nxt_sel;
      end
   end

   athr_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_hash_act (.row(act_row), .idx(act_idx));
   athr_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_hash_ref (.row(ref_row), .idx(ref_idx));

   for (genvar f = 0; f < 2; f++) begin : g_filt
      athr_cbf #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_cbf (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (ep_wrap && (act_sel == 1'(f))),
         .inc_en  (act_eff),
         .inc_idx (act_idx),
         .hd_en   (ref_vld),
         .hd_idx  (ref_idx),
         .inc_min (inc_min[f]),
         .hd_min  (hd_min[f])
      );
   end

   assign est_act = inc_min[nxt_sel];
   assign est_ref = hd_min[nxt_sel];
   assign add_en  = act_eff && (est_act > CNT_W'(THRESH));
   assign rm_en   = ref_vld && (est_ref <= CNT_W'(THRESH));

   athr_blist #(.ROW_W(ROW_W), .BL_DEPTH(BL_DEPTH), .MIN_GAP(MIN_GAP)) u_blist (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (ep_wrap),
      .add_en     (add_en),
      .add_row    (act_row),
      .rm_en      (rm_en),
      .rm_row     (ref_row),
      .touch_en   (act_eff),
      .touch_row  (act_row),
      .qry_row    (qry_row),
      .qry_hit    (hit_w),
      .qry_gap_ok (gap_ok_w),
      .count      (bl_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qry_bl_hit <= 1'b0;
         qry_allow  <= 1'b1;
      end else begin
         qry_bl_hit <= qry_vld && hit_w;
         qry_allow  <= !qry_vld || !hit_w || gap_ok_w;
      end
   end
endmodule

module athr_throttle_chk #(
   parameter int ROW_W    = 16,
   parameter int BL_DEPTH = 8,
   parameter int BLC_W    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             act_vld,
   input logic [ROW_W-1:0] act_row,
   input logic             ref_vld,
   input logic [ROW_W-1:0] ref_row,
   input logic             qry_vld,
   input logic             qry_bl_hit,
   input logic             qry_allow,
   input logic [BLC_W-1:0] bl_count,
   input logic             ep_wrap
);
   // R8: occupancy never exceeds capacity
   p_count_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, bl_count} <= (BLC_W+1)'(BL_DEPTH));

   // R8: at most one row joins per edge
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> {1'b0, bl_count} <= {1'b0, $past(bl_count)} + 1'b1);

   // R2: no activation, no growth
   p_idle_no_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !act_vld |=> bl_count <= $past(bl_count));

   // R7: refresh beats activation of the same row
   p_same_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vld && ref_vld && act_row == ref_row) |=> bl_count <= $past(bl_count));

   // R9: epoch boundary empties the list (one row may join on that edge)
   p_epoch_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ep_wrap |=> {1'b0, bl_count} <= (BLC_W+1)'(1));

   // R3: an empty list never reports a hit
   p_empty_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_vld && bl_count == '0) |=> !qry_bl_hit);

   // R3: idle query slot reads as allowed
   p_idle_allow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_vld |=> (qry_allow && !qry_bl_hit));
endmodule

bind athr_throttle athr_throttle_chk #(.ROW_W(ROW_W), .BL_DEPTH(BL_DEPTH), .BLC_W(BLC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .act_vld    (act_vld),
   .act_row    (act_row),
   .ref_vld    (ref_vld),
   .ref_row    (ref_row),
   .qry_vld    (qry_vld),
   .qry_bl_hit (qry_bl_hit),
   .qry_allow  (qry_allow),
   .bl_count   (bl_count),
   .ep_wrap    (ep_wrap)
);

// File: tb/athr_throttle_bench.sv
`timescale 1ns/1ps
module athr_throttle_bench;
   localparam int ROW_W = 12, IDX_W = 4, CNT_W = 8, THRESH = 100;
   localparam int EPOCH_CYC = 1000, MIN_GAP = 5, BL_DEPTH = 2;
   localparam int BLC_W = $clog2(BL_DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic act_vld = 1'b0, ref_vld = 1'b0, qry_vld = 1'b0;
   logic [ROW_W-1:0] act_row = '0, ref_row = '0, qry_row = '0;
   logic qry_bl_hit, qry_allow;
   logic [BLC_W-1:0] bl_count;
   int n_tests = 0, n_fail = 0, cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   athr_throttle #(.ROW_W(ROW_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .THRESH(THRESH),
      .EPOCH_CYC(EPOCH_CYC), .MIN_GAP(MIN_GAP), .BL_DEPTH(BL_DEPTH)) u_athr_throttle (
      .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_row(act_row),
      .ref_vld(ref_vld), .ref_row(ref_row), .qry_vld(qry_vld), .qry_row(qry_row),
      .qry_bl_hit(qry_bl_hit), .qry_allow(qry_allow), .bl_count(bl_count));

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; act_vld = 0; ref_vld = 0; qry_vld = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic act(input int row, input int n);
      act_vld = 1'b1; act_row = ROW_W'(row);
      repeat (n) @(negedge clk);
      act_vld = 1'b0;
   endtask

   task automatic refresh(input int row);
      ref_vld = 1'b1; ref_row = ROW_W'(row);
      @(negedge clk);
      ref_vld = 1'b0;
   endtask

   task automatic query(input string req, input int row, input int exp_hit, input int exp_allow);
      qry_vld = 1'b1; qry_row = ROW_W'(row);
      @(negedge clk);
      qry_vld = 1'b0;
      check({req, " hit"}, int'(qry_bl_hit), exp_hit);
      check({req, " allow"}, int'(qry_allow), exp_allow);
   endtask

   // Rows 1, 2, 3 share no counter in any bank under the R2 hashes.
   task automatic t_reset_r1();
      do_reset();
      @(negedge clk);
      check("R1 count", int'(bl_count), 0);
      check("R1 hit", int'(qry_bl_hit), 0);
      check("R1 allow", int'(qry_allow), 1);
   endtask

   task automatic t_threshold_r2();
      do_reset();
      act(1, THRESH);
      check("R2 count at threshold", int'(bl_count), 0);
      query("R3 clean row", 1, 0, 1);
      act(1, 1);
      check("R2 count above threshold", int'(bl_count), 1);
      query("R2 listed row", 1, 1, 0);
      query("R3 other row", 2, 0, 1);
   endtask

   task automatic t_spacing_r4();
      do_reset();
      act(1, THRESH + 1);
      idle(MIN_GAP - 1);
      query("R4 before gap", 1, 1, 0);
      query("R4 at gap", 1, 1, 1);
      act(1, 1);
      query("R4 restart", 1, 1, 0);
   endtask

   task automatic t_half_delete_r5();
      do_reset();
      act(1, THRESH + 1);
      refresh(1);
      check("R5 removed", int'(bl_count), 0);
      query("R5 removed row", 1, 0, 1);
      do_reset();
      act(2, 210);
      refresh(2);
      check("R5 stays at 105", int'(bl_count), 1);
      refresh(2);
      check("R5 leaves at 52", int'(bl_count), 0);
   endtask

   task automatic t_saturate_r6();
      do_reset();
      act(3, 400);
      refresh(3);
      check("R6 saturated half stays", int'(bl_count), 1);
      refresh(3);
      check("R6 second half leaves", int'(bl_count), 0);
   endtask

   task automatic t_same_cycle_r7();
      do_reset();
      act(1, 201);
      act_vld = 1'b1; act_row = ROW_W'(1);
      ref_vld = 1'b1; ref_row = ROW_W'(1);
      @(negedge clk);
      act_vld = 1'b0; ref_vld = 1'b0;
      check("R7 refresh wins", int'(bl_count), 0);
      act(1, 1);
      check("R7 count was 100", int'(bl_count), 1);
   endtask

   task automatic t_capacity_r8();
      do_reset();
      act(1, THRESH + 1);
      act(2, THRESH + 1);
      act(3, THRESH + 1);
      check("R8 full", int'(bl_count), BL_DEPTH);
      query("R8 overflow row", 3, 0, 1);
      refresh(1);
      check("R8 slot freed", int'(bl_count), 1);
      act(3, 1);
      check("R8 slot reused", int'(bl_count), 2);
      query("R8 reused row", 3, 1, 0);
   endtask

   task automatic t_epoch_r9();
      do_reset();
      act(1, 150);
      check("R9 listed", int'(bl_count), 1);
      while (cyc < EPOCH_CYC + 100) @(negedge clk);
      check("R9 flushed", int'(bl_count), 0);
      act(1, 1);
      check("R9 requalify", int'(bl_count), 1);
      while (cyc < 2 * EPOCH_CYC + 100) @(negedge clk);
      check("R9 second flush", int'(bl_count), 0);
      act(1, THRESH - 1);
      check("R9 old history gone", int'(bl_count), 0);
      act(1, 1);
      check("R9 new count", int'(bl_count), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_r1();
      t_threshold_r2();
      t_spacing_r4();
      t_half_delete_r5();
      t_saturate_r6();
      t_same_cycle_r7();
      t_capacity_r8();
      t_epoch_r9();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule